// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a 24-bit control word into an external programmable clock synthesizer over a two-wire interface made of a serial clock line and a serial data line. A host pulses a start input while presenting four divider fields. The block captures the fields and packs them into the control word. It then drives the wires through an unlock preamble, a start bit, the 24 data bits and a stop bit. Each data bit uses a modified Manchester format: the inverted bit is on the data line when the serial clock falls, and the true bit is on the data line when the serial clock rises.

The block holds every level pair on the wires for a fixed number of system clocks, set by a parameter. It repeats the whole load back-to-back a parameterised number of times, three by default, so that the synthesizer reliably accepts the word. A busy output covers the whole operation. A single-cycle done pulse marks the end of the final repetition. Between loads both wires rest high.

Top module: `clksyn_loader`

## Requirements
- R1: While reset is held and whenever no load is running, ser_clk and ser_data are both 1, and prog_busy and prog_done are 0.
- R2: The control word, bit 23 down to bit 0, is: a 0 at bit 23, the constant 2'b10 at bits 22:21, fld_index at 20:17, fld_n at 16:10, fld_p at 9:7 and fld_d at 6:0. The fields are taken in the cycle the start is accepted.
- R3: Each load opens with this preamble of {ser_clk,ser_data} pairs: 00, 01, then UNLOCK_PULSES repetitions of 11, 01, then 00, 10.
- R4: The start bit follows the preamble as the pairs 00, 10.
- R5: The 24 word bits follow, least significant first. A bit b is sent as the pairs {1,~b}, {0,~b}, {0,b}, {1,b}.
- R6: The stop bit closes the load as the pairs 11, 01, 11.
- R7: Each pair is held for exactly PHASE_CYCLES clock cycles. The first pair of a load appears in the cycle after the clock edge that samples prog_start high. prog_busy is high for the whole sequence.
- R8: The full load, from preamble to stop bit, is sent LOAD_REPEATS times with no gap between repetitions, and every repetition carries the same word.
- R9: In the cycle after the final pair ends, prog_busy falls, prog_done is high for exactly that one cycle, and both wires return to 1.
- R10: A prog_start pulse, or a change of the fields, while prog_busy is high has no effect on the wires or on the end time of the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Request a load; accepted only while idle |
| fld_index | input | 4 | Index field of the control word |
| fld_n | input | 7 | N divider field |
| fld_p | input | 3 | P divider field |
| fld_d | input | 7 | D divider field |
| prog_busy | output | 1 | High while a load sequence is running |
| prog_done | output | 1 | One-cycle pulse after the last repetition |
| ser_clk | output | 1 | Serial clock line to the synthesizer |
| ser_data | output | 1 | Serial data line to the synthesizer |

## Verification
The bench compares every cycle of each run against a pair list built from the word format. Stimulus includes all-zero, all-one and alternating field values, so a design that swaps the complement and true halves of a bit, or shifts the word out most significant bit first, produces a mismatch in the data region. A load that ends one repetition early, or a pair that is held one cycle too long or too short, shows up as busy or level mismatches at a known cycle count. A run that pulses start and scrambles the fields halfway through exposes a design that restarts or re-latches its word while busy. The done checks catch a pulse that is late, missing or longer than one cycle.

// File: rtl/clksyn_pkg.sv
// Package: shared constants, segment encoding and the level decode used
// by the clock synthesizer serial programmer.
// Assumes the serial pair is represented as {clock, data}.
package clksyn_pkg;

    localparam int WORD_W = 24;
    localparam int IDX_W  = 4;
    localparam int N_W    = 7;
    localparam int P_W    = 3;
    localparam int D_W    = 7;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [1:0] REG_SELECT = 2'b10;
    localparam logic [1:0] PAIR_IDLE  = 2'b11;

    typedef enum logic [2:0] {
        SEG_LEAD,
        SEG_UNLOCK,
        SEG_ARM,
        SEG_START,
        SEG_BITS,
        SEG_STOP
    } seg_e;

    // Map a segment position to the {clock, data} levels it shows.
    function automatic logic [1:0] seg_levels(input seg_e seg,
                                              input logic [1:0] sub,
                                              input logic bitv);
        logic [1:0] lv;
        case (seg)
            SEG_LEAD:   lv = (sub == 2'd0) ? 2'b00 : 2'b01;
            SEG_UNLOCK: lv = sub[0] ? 2'b01 : 2'b11;
            SEG_ARM,
            SEG_START:  lv = (sub == 2'd0) ? 2'b00 : 2'b10;
            SEG_BITS:   lv = {(sub == 2'd0) || (sub == 2'd3),
                              sub[1] ? bitv : ~bitv};
            SEG_STOP:   lv = (sub == 2'd1) ? 2'b01 : 2'b11;
            default:    lv = PAIR_IDLE;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/clksyn_word_pack.sv
// Module: clksyn_word_pack
// Packs the divider fields and the fixed register-select code into the
// 24-bit control word. Purely combinational; assumes the field widths
// from clksyn_pkg add up to the word width together with bits 23:21.
module clksyn_word_pack
    import clksyn_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [N_W-1:0]    nval,
    input  logic [P_W-1:0]    pval,
    input  logic [D_W-1:0]    dval,
    output logic [WORD_W-1:0] word
);

    // Concatenate the fields into their fixed bit positions.
    always_comb begin
        word = {1'b0, REG_SELECT, idx, nval, pval, dval};
    end

endmodule

// File: rtl/clksyn_phase_timer.sv
// Module: clksyn_phase_timer
// Counts system clocks inside one wire phase and flags the last cycle of
// each phase. Assumes PHASE_CYCLES >= 1 and that clear and run are
// never high together.
module clksyn_phase_timer #(
    parameter int PHASE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final cycle of the current phase while running.
    always_comb begin
        expire = run && (cnt_q == CNT_LAST);
    end

    // Advance the phase counter and wrap it at the end of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clksyn_wire_seq.sv
// Module: clksyn_wire_seq
// Walks the load sequence (preamble, start bit, data bits, stop bit) and
// repeats it LOAD_REPEATS times. It registers the serial clock/data levels
// and issues busy/done. Assumes step comes from the phase timer and that
// word is stable from the cycle after accept until done.
module clksyn_wire_seq
    import clksyn_pkg::*;
#(
    parameter int UNLOCK_PULSES = 5,
    parameter int LOAD_REPEATS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [WORD_W-1:0] word,
    output logic              accept,
    output logic              active,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data
);

    localparam int SUB_RAW = $clog2(2 * UNLOCK_PULSES);
    localparam int SUB_W   = (SUB_RAW > 2) ? SUB_RAW : 2;
    localparam int REP_W   = (LOAD_REPEATS > 1) ? $clog2(LOAD_REPEATS) : 1;
    localparam logic [SUB_W-1:0] SUB_ONE     = SUB_W'(1);
    localparam logic [SUB_W-1:0] SUB_TWO     = SUB_W'(2);
    localparam logic [SUB_W-1:0] SUB_THREE   = SUB_W'(3);
    localparam logic [SUB_W-1:0] UNLOCK_LAST = SUB_W'(2 * UNLOCK_PULSES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST    = BIT_W'(WORD_W - 1);
    localparam logic [REP_W-1:0] REP_LAST    = REP_W'(LOAD_REPEATS - 1);

    seg_e             seg_q,  seg_n;
    logic [SUB_W-1:0] sub_q,  sub_n;
    logic [BIT_W-1:0] bit_q,  bit_n;
    logic [REP_W-1:0] rep_q,  rep_n;
    logic             act_q,  act_n;
    logic             finish;
    logic             done_q;
    logic [1:0]       pair_q;

    // Accept a start request only while no load is running.
    always_comb begin
        accept = start && !act_q;
    end

    // Work out the next sequence position from the current one.
    always_comb begin
        seg_n  = seg_q;
        sub_n  = sub_q;
        bit_n  = bit_q;
        rep_n  = rep_q;
        act_n  = act_q;
        finish = 1'b0;
        if (accept) begin
            seg_n = SEG_LEAD;
            sub_n = '0;
            bit_n = '0;
            rep_n = '0;
            act_n = 1'b1;
        end else if (act_q && step) begin
            sub_n = sub_q + 1'b1;
            case (seg_q)
                SEG_LEAD: begin
                    if (sub_q == SUB_ONE) begin
                        seg_n = SEG_UNLOCK;
                        sub_n = '0;
                    end
                end
                SEG_UNLOCK: begin
                    if (sub_q == UNLOCK_LAST) begin
                        seg_n = SEG_ARM;
                        sub_n = '0;
                    end
                end
                SEG_ARM: begin
                    if (sub_q == SUB_ONE) begin
                        seg_n = SEG_START;
                        sub_n = '0;
                    end
                end
                SEG_START: begin
                    if (sub_q == SUB_ONE) begin
                        seg_n = SEG_BITS;
                        sub_n = '0;
                        bit_n = '0;
                    end
                end
                SEG_BITS: begin
                    if (sub_q == SUB_THREE) begin
                        sub_n = '0;
                        if (bit_q == BIT_LAST) begin
                            seg_n = SEG_STOP;
                        end else begin
                            bit_n = bit_q + 1'b1;
                        end
                    end
                end
                SEG_STOP: begin
                    if (sub_q == SUB_TWO) begin
                        seg_n = SEG_LEAD;
                        sub_n = '0;
                        if (rep_q == REP_LAST) begin
                            finish = 1'b1;
                            act_n  = 1'b0;
                        end else begin
                            rep_n = rep_q + 1'b1;
                        end
                    end
                end
                default: begin
                    seg_n = SEG_LEAD;
                    sub_n = '0;
                end
            endcase
        end
    end

    // Hold the sequence position, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= SEG_LEAD;
            sub_q  <= '0;
            bit_q  <= '0;
            rep_q  <= '0;
            act_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            seg_q  <= seg_n;
            sub_q  <= sub_n;
            bit_q  <= bit_n;
            rep_q  <= rep_n;
            act_q  <= act_n;
            done_q <= finish;
        end
    end

    // Register the wire levels of the position being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= PAIR_IDLE;
        end else if (act_n) begin
            pair_q <= seg_levels(seg_n, sub_n[1:0], word[bit_n]);
        end else begin
            pair_q <= PAIR_IDLE;
        end
    end

    // Drive the outputs from their registers.
    always_comb begin
        active   = act_q;
        done     = done_q;
        ser_clk  = pair_q[1];
        ser_data = pair_q[0];
    end

    // R1: both wires rest high whenever no load runs.
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (pair_q == PAIR_IDLE));

    // R7: the levels do not move inside a phase.
    a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && $past(act_q) && !$past(step)) |-> $stable(pair_q));

    // R9: done never overlaps busy.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !act_q);

    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10: a start seen while busy leaves the load running.
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && start && !step) |=> act_q);

endmodule

// File: rtl/clksyn_loader.sv
// Module: clksyn_loader (top)
// Serial programmer for a clock synthesizer: captures the divider fields
// when a start is accepted and drives the two-wire load sequence.
// Assumes prog_start is synchronous to clk; PHASE_CYCLES >= 1,
// UNLOCK_PULSES >= 5 and LOAD_REPEATS >= 1.
module clksyn_loader
    import clksyn_pkg::*;
#(
    parameter int PHASE_CYCLES  = 4,
    parameter int UNLOCK_PULSES = 5,
    parameter int LOAD_REPEATS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start,
    input  logic [IDX_W-1:0] fld_index,
    input  logic [N_W-1:0]   fld_n,
    input  logic [P_W-1:0]   fld_p,
    input  logic [D_W-1:0]   fld_d,
    output logic             prog_busy,
    output logic             prog_done,
    output logic             ser_clk,
    output logic             ser_data
);

    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] word_q;
    logic              accept;
    logic              busy_int;
    logic              step;

    clksyn_word_pack u_pack (
        .idx  (fld_index),
        .nval (fld_n),
        .pval (fld_p),
        .dval (fld_d),
        .word (word_in)
    );

    // Capture the packed word when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= word_in;
        end
    end

    clksyn_phase_timer #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .run    (busy_int),
        .expire (step)
    );

    clksyn_wire_seq #(
        .UNLOCK_PULSES (UNLOCK_PULSES),
        .LOAD_REPEATS  (LOAD_REPEATS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (prog_start),
        .step     (step),
        .word     (word_q),
        .accept   (accept),
        .active   (busy_int),
        .done     (prog_done),
        .ser_clk  (ser_clk),
        .ser_data (ser_data)
    );

    // Expose the busy flag.
    always_comb begin
        prog_busy = busy_int;
    end

    // R2: the captured word stays fixed for the whole load.
    a_r2_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_int && $past(busy_int)) |-> $stable(word_q));

endmodule

// File: tb/clksyn_loader_bench.sv
module clksyn_loader_bench;

    localparam int PH   = 3;
    localparam int UNL  = 5;
    localparam int REPS = 3;
    localparam int PRE_END   = 4 + 2 * UNL;
    localparam int START_END = PRE_END + 2;
    localparam int BITS_END  = START_END + 96;
    localparam int LOAD_LEN  = BITS_END + 3;
    localparam int RUN_CYC   = LOAD_LEN * REPS * PH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_start = 1'b0;
    logic [3:0] fld_index = '0;
    logic [6:0] fld_n = '0;
    logic [2:0] fld_p = '0;
    logic [6:0] fld_d = '0;
    logic       prog_busy, prog_done, ser_clk, ser_data;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [1:0] exp_st [0:LOAD_LEN-1];
    int         exp_len;

    always #2 clk = ~clk;

    clksyn_loader #(
        .PHASE_CYCLES  (PH),
        .UNLOCK_PULSES (UNL),
        .LOAD_REPEATS  (REPS)
    ) u_clksyn_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_start (prog_start),
        .fld_index  (fld_index),
        .fld_n      (fld_n),
        .fld_p      (fld_p),
        .fld_d      (fld_d),
        .prog_busy  (prog_busy),
        .prog_done  (prog_done),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exv);
        end
    endtask

    task automatic put(input logic [1:0] v);
        exp_st[exp_len] = v;
        exp_len++;
    endtask

    // Pair list for one load, derived from R3..R6.
    task automatic build_expected(input logic [23:0] w);
        exp_len = 0;
        put(2'b00); put(2'b01);
        for (int u = 0; u < UNL; u++) begin
            put(2'b11); put(2'b01);
        end
        put(2'b00); put(2'b10);
        put(2'b00); put(2'b10);
        for (int b = 0; b < 24; b++) begin
            put({1'b1, ~w[b]}); put({1'b0, ~w[b]});
            put({1'b0,  w[b]}); put({1'b1,  w[b]});
        end
        put(2'b11); put(2'b01); put(2'b11);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(ser_clk == 1'b1, "R1 clk high in reset", ser_clk, 1);
        check(ser_data == 1'b1, "R1 data high in reset", ser_data, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(prog_busy == 1'b0, "R1 busy low idle", prog_busy, 0);
        check(prog_done == 1'b0, "R1 done low idle", prog_done, 0);
    endtask

    // One full load; when disturb is set, start and fields change mid-run.
    task automatic t_load(input logic [3:0] ix, input logic [6:0] nv,
                          input logic [2:0] pv, input logic [6:0] dv,
                          input bit disturb);
        int         miss [0:4];
        logic [1:0] fa   [0:4];
        logic [1:0] fe   [0:4];
        int         busy_miss = 0;
        int         all_miss  = 0;
        logic [23:0] w;
        w = {1'b0, 2'b10, ix, nv, pv, dv};
        build_expected(w);
        for (int c = 0; c < 5; c++) begin
            miss[c] = 0; fa[c] = 2'b00; fe[c] = 2'b00;
        end
        fld_index = ix; fld_n = nv; fld_p = pv; fld_d = dv;
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        for (int i = 0; i < RUN_CYC; i++) begin
            int s; int r; int m; int cat;
            logic [1:0] act;
            s = i / PH; r = s / LOAD_LEN; m = s % LOAD_LEN;
            act = {ser_clk, ser_data};
            if (prog_busy !== 1'b1) busy_miss++;
            if (act !== exp_st[m]) begin
                all_miss++;
                if (r > 0)               cat = 4;
                else if (m < PRE_END)    cat = 0;
                else if (m < START_END)  cat = 1;
                else if (m < BITS_END)   cat = 2;
                else                     cat = 3;
                if (miss[cat] == 0) begin
                    fa[cat] = act; fe[cat] = exp_st[m];
                end
                miss[cat]++;
            end
            if (disturb && i == 400) begin
                prog_start = 1'b1;
                fld_index = ~ix; fld_n = ~nv; fld_p = ~pv; fld_d = ~dv;
            end
            if (disturb && i == 401) prog_start = 1'b0;
            @(negedge clk);
        end
        check(miss[0] == 0, "R3 unlock preamble", fa[0], fe[0]);
        check(miss[1] == 0, "R4 start bit", fa[1], fe[1]);
        check(miss[2] == 0, "R2 R5 data bits lsb first", fa[2], fe[2]);
        check(miss[3] == 0, "R6 stop bit", fa[3], fe[3]);
        check(miss[4] == 0, "R8 later repetitions", fa[4], fe[4]);
        check(busy_miss == 0, "R7 busy over full timed sequence", busy_miss, 0);
        if (disturb)
            check(all_miss == 0, "R10 start while busy ignored", all_miss, 0);
        check(prog_busy == 1'b0, "R9 busy falls at end", prog_busy, 0);
        check(prog_done == 1'b1, "R9 done pulse at end", prog_done, 1);
        check({ser_clk, ser_data} == 2'b11, "R9 wires idle at end",
              {ser_clk, ser_data}, 2'b11);
        @(negedge clk);
        check(prog_done == 1'b0, "R9 done lasts one cycle", prog_done, 0);
        check({ser_clk, ser_data, prog_busy} == 3'b110, "R1 idle after load",
              {ser_clk, ser_data, prog_busy}, 3'b110);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load(4'hA, 7'h55, 3'd5, 7'h2A, 1'b0);
        t_load(4'h0, 7'h00, 3'd0, 7'h00, 1'b0);
        t_load(4'hF, 7'h7F, 3'd7, 7'h7F, 1'b0);
        t_load(4'h3, 7'h19, 3'd2, 7'h46, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule